// File: doc/BRIEF.md
# Interrupt Return Sequencer

This block carries out the return from an interrupt or exception handler. When `start` is pulsed it looks at the current machine state and picks one of several return flavours. The state it uses is the protection-enable and long-mode-active bits, the current flags image, the current privilege level and the operand size. It then pulls the saved words one at a time through a request/acknowledge read port on the stack. From those words it builds the restored instruction pointer, code selector, flags image and, where the flavour needs it, a new stack pointer, stack selector and four data segment selectors.

The first three pops are always the instruction pointer, the code selector and the flags image. The popped flags and the privilege field of the popped code selector then decide whether more pops follow. The extra pops are a stack pointer and stack selector for a return to a less privileged level or within long mode, plus the four data selectors for a return into virtual-8086 operation. Two cases pop nothing. A nested task return only raises a flag for the task-switch logic elsewhere. The forbidden combinations raise a general-protection fault. Every outcome ends in a single `done` pulse. A faulting or task-return outcome leaves the restored-state outputs exactly as they were.

Top module: `iret_seq`

## Requirements
- R1: After reset every restored-state output is zero, and `pop_req`, `done`, `fault_valid` and `task_ret` are low.
- R2: Pop k (counting from 0) reads address `sp_in + k*step`. The step is 2, 4 or 8 bytes for `osize` code 0, 1 or 2, which select 16-, 32- or 64-bit operands. When `pe` is 0, exactly three pops are made, in the order instruction pointer, code selector, flags image.
- R3: Each popped word is cut to the operand width, so a 16-bit instruction pointer pop is zero-extended. Every selector keeps only the low 16 bits of its pop. A flags image keeps the low 32 bits.
- R4: On the real-address path with 16-bit operands, the flags output is `{flags_in[31:16], pop[15:0]}`. With 32-bit operands it is `(pop & 0x257FD5) | (flags_in & 0x1A0000)`.
- R5: With `pe`=1, `lma`=0 and the VM bit (`flags_in[17]`) set, a privilege field `flags_in[13:12]` below 3 gives a general-protection fault and no pops. At 3, three pops are made. With 32-bit operands, bits 20, 19, 17, 13 and 12 of the flags output are then taken from `flags_in` and the rest from the pop.
- R6: When the nested-task bit (`flags_in[14]`) is set, protected mode (not long, VM clear) gives `task_ret` and long mode gives a general-protection fault. In both cases no pop is made.
- R7: In protected mode, if the popped flags have bit 17 set and `cpl_in` is 0, six more pops follow: stack pointer, stack selector, then the selectors ES, DS, FS and GS. `sel_out` packs them as {GS,FS,DS,ES} from the most significant slice down, and `cpl_out` becomes 3.
- R8: Otherwise, in protected or long mode, a popped code selector whose low two bits exceed `cpl_in` gives two more pops: stack pointer, then stack selector. `sp_out` and `ss_out` take the popped values and `cpl_out` takes the selector's low two bits.
- R9: On the R8 path, a data selector is forced to zero if bits 15:2 of it are zero. It is also forced to zero if its `seg_dpl` field is below the new privilege level while its `seg_dnc` bit is set. Otherwise it passes through. Slot i uses `seg_dpl[2i+1:2i]` and `seg_dnc[i]`.
- R10: A protected-mode return to the same level makes no further pops. `sp_out` is `sp_in` plus three steps, and `ss_out`, `sel_out` and `cpl_out` pass `ss_in`, `sel_in` and `cpl_in` through.
- R11: A long-mode return to the same level always pops a stack pointer and stack selector. The data selectors and `cpl_in` pass through unchanged.
- R12: Outside long mode, a restored instruction pointer above `cs_limit` gives a general-protection fault right after the third pop, and no further pop is made.
- R13: `pop_req` stays high with `pop_addr` unchanged until `pop_ack`. Each acknowledged cycle consumes exactly one word.
- R14: Every return ends with `done` high for one cycle. A fault sets `fault_valid` with `fault_code` 13 and changes no restored-state output. A `start` that arrives while a return is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an interrupt return |
| pe | input | 1 | Protection enabled |
| lma | input | 1 | Long mode active |
| flags_in | input | 32 | Current flags image (VM bit 17, NT bit 14, IOPL bits 13:12) |
| cpl_in | input | 2 | Current privilege level |
| osize | input | 2 | Operand size code: 0=16, 1=32, 2=64 bit |
| sp_in | input | 64 | Current stack pointer |
| ss_in | input | 16 | Current stack selector |
| sel_in | input | 64 | Current data selectors {GS,FS,DS,ES} |
| seg_dpl | input | 8 | Descriptor privilege per data selector slot |
| seg_dnc | input | 4 | Descriptor is data or non-conforming code, per slot |
| cs_limit | input | 32 | Code segment limit |
| pop_req | output | 1 | Stack read request |
| pop_addr | output | 64 | Stack read address |
| pop_ack | input | 1 | Stack read acknowledge, data valid |
| pop_data | input | 64 | Stack read data |
| done | output | 1 | Return finished (one-cycle pulse) |
| fault_valid | output | 1 | Return ended in a fault |
| fault_code | output | 8 | Fault vector (13 = general protection, error code zero) |
| task_ret | output | 1 | Nested task return requested |
| ip_out | output | 64 | Restored instruction pointer |
| cs_out | output | 16 | Restored code selector |
| flags_out | output | 32 | Restored flags image |
| sp_out | output | 64 | Restored stack pointer |
| ss_out | output | 16 | Restored stack selector |
| sel_out | output | 64 | Restored data selectors {GS,FS,DS,ES} |
| cpl_out | output | 2 | New privilege level |

## Verification
Some properties are checked on every cycle regardless of path. A stalled read keeps its request and address. Back-to-back pops advance the address by one operand step. A fault or task-return pulse leaves every restored output untouched, and `done` never coincides with a pending read. The path selection, the pop count per flavour, the flags merge rules, the selector sanitising, the limit fault and the ignored mid-flight `start` depend on specific stack contents and mode settings. Only the bench's scenarios show those, compared against its own model of the stack and of the expected architectural state.

// File: rtl/iret_seq_pkg.sv
package iret_seq_pkg;

    localparam int XLEN = 64;
    localparam int FLW  = 32;

    localparam int FLAG_VM   = 17;
    localparam int FLAG_NT   = 14;
    localparam int FLAG_PL_H = 13;
    localparam int FLAG_PL_L = 12;

    localparam logic [FLW-1:0] REAL_POP_KEEP = 32'h0025_7FD5;
    localparam logic [FLW-1:0] REAL_CUR_KEEP = 32'h001A_0000;
    localparam logic [FLW-1:0] V86_CUR_KEEP  = 32'h001A_3000;

    localparam logic [7:0] VEC_GP = 8'd13;

    typedef enum logic [2:0] {
        H_REAL, H_FROM_V86, H_PROT, H_LONG, H_TASK, H_FAULT
    } head_e;

    typedef enum logic [1:0] {
        T_NONE, T_OUTER, T_TO_V86, T_STACK
    } tail_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HEAD, S_DECIDE, S_TAIL, S_COMMIT
    } state_e;

    function automatic logic [XLEN-1:0] opnd_mask(input logic [1:0] os);
        case (os)
            2'd0:    return 64'h0000_0000_0000_FFFF;
            2'd1:    return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/iret_path_sel.sv
module iret_path_sel
    import iret_seq_pkg::*;
(
    input  logic           pe,
    input  logic           lma,
    input  logic [FLW-1:0] flags_cur,
    input  logic [1:0]     cpl,
    input  head_e          head_taken,
    input  logic [FLW-1:0] flags_popped,
    input  logic [1:0]     rpl_popped,
    output head_e          head_now,
    output tail_e          tail_now
);

    logic       vm_cur;
    logic       nt_cur;
    logic [1:0] pl_cur;

    assign vm_cur = flags_cur[FLAG_VM];
    assign nt_cur = flags_cur[FLAG_NT];
    assign pl_cur = flags_cur[FLAG_PL_H:FLAG_PL_L];

    always_comb begin
        if (!pe)              head_now = H_REAL;
        else if (lma)         head_now = nt_cur ? H_FAULT : H_LONG;
        else if (vm_cur)      head_now = (pl_cur == 2'd3) ? H_FROM_V86 : H_FAULT;
        else if (nt_cur)      head_now = H_TASK;
        else                  head_now = H_PROT;
    end

    always_comb begin
        unique case (head_taken)
            H_PROT: begin
                if (flags_popped[FLAG_VM] && cpl == 2'd0) tail_now = T_TO_V86;
                else if (rpl_popped > cpl)                tail_now = T_OUTER;
                else                                      tail_now = T_NONE;
            end
            H_LONG:  tail_now = (rpl_popped > cpl) ? T_OUTER : T_STACK;
            default: tail_now = T_NONE;
        endcase
    end

endmodule

// File: rtl/iret_seg_clean.sv
module iret_seg_clean #(
    parameter int NSEG = 4,
    parameter int SELW = 16
) (
    input  logic [NSEG*SELW-1:0] sel_in,
    input  logic [NSEG*2-1:0]    dpl_in,
    input  logic [NSEG-1:0]      dnc_in,
    input  logic [1:0]           new_cpl,
    output logic [NSEG*SELW-1:0] sel_out
);

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        logic [SELW-1:0] sel_g;
        logic            is_null;
        logic            too_priv;

        assign sel_g    = sel_in[g*SELW +: SELW];
        assign is_null  = (sel_g[SELW-1:2] == '0);
        assign too_priv = dnc_in[g] && (dpl_in[g*2 +: 2] < new_cpl);
        assign sel_out[g*SELW +: SELW] = (is_null || too_priv) ? '0 : sel_g;
    end

endmodule

// File: rtl/iret_seq.sv
module iret_seq
    import iret_seq_pkg::*;
#(
    parameter int NSEG = 4,
    parameter int SELW = 16,
    parameter int LIMW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 pe,
    input  logic                 lma,
    input  logic [FLW-1:0]       flags_in,
    input  logic [1:0]           cpl_in,
    input  logic [1:0]           osize,
    input  logic [XLEN-1:0]      sp_in,
    input  logic [SELW-1:0]      ss_in,
    input  logic [NSEG*SELW-1:0] sel_in,
    input  logic [NSEG*2-1:0]    seg_dpl,
    input  logic [NSEG-1:0]      seg_dnc,
    input  logic [LIMW-1:0]      cs_limit,
    output logic                 pop_req,
    output logic [XLEN-1:0]      pop_addr,
    input  logic                 pop_ack,
    input  logic [XLEN-1:0]      pop_data,
    output logic                 done,
    output logic                 fault_valid,
    output logic [7:0]           fault_code,
    output logic                 task_ret,
    output logic [XLEN-1:0]      ip_out,
    output logic [SELW-1:0]      cs_out,
    output logic [FLW-1:0]       flags_out,
    output logic [XLEN-1:0]      sp_out,
    output logic [SELW-1:0]      ss_out,
    output logic [NSEG*SELW-1:0] sel_out,
    output logic [1:0]           cpl_out
);

    localparam int HEAD_POPS = 3;
    localparam int TAIL_MAX  = NSEG + 2;
    localparam int IDXW      = $clog2(TAIL_MAX + 1);
    localparam int SELS      = NSEG * SELW;

    typedef struct packed {
        state_e          st;
        head_e           head;
        tail_e           tail;
        logic [IDXW-1:0] idx;
        logic [XLEN-1:0] ptr;
        logic [XLEN-1:0] ip;
        logic [SELW-1:0] cs;
        logic [FLW-1:0]  fl;
        logic [XLEN-1:0] tsp;
        logic [SELW-1:0] tss;
        logic [SELS-1:0] tsel;
        logic            done;
        logic            fv;
        logic            tret;
        logic [7:0]      fcode;
        logic [XLEN-1:0] o_ip;
        logic [SELW-1:0] o_cs;
        logic [FLW-1:0]  o_fl;
        logic [XLEN-1:0] o_sp;
        logic [SELW-1:0] o_ss;
        logic [SELS-1:0] o_sel;
        logic [1:0]      o_cpl;
    } seq_t;

    seq_t q, d;

    head_e           head_now;
    tail_e           tail_now;
    logic [SELS-1:0] sel_clean;
    logic [XLEN-1:0] step_w;
    logic [XLEN-1:0] pop_w;
    logic [FLW-1:0]  fl_new;
    logic            os16;

    assign step_w = XLEN'(2) << osize;
    assign pop_w  = pop_data & opnd_mask(osize);
    assign os16   = (osize == 2'd0);

    iret_path_sel u_path (
        .pe           (pe),
        .lma          (lma),
        .flags_cur    (flags_in),
        .cpl          (cpl_in),
        .head_taken   (q.head),
        .flags_popped (q.fl),
        .rpl_popped   (q.cs[1:0]),
        .head_now     (head_now),
        .tail_now     (tail_now)
    );

    iret_seg_clean #(.NSEG(NSEG), .SELW(SELW)) u_clean (
        .sel_in  (sel_in),
        .dpl_in  (seg_dpl),
        .dnc_in  (seg_dnc),
        .new_cpl (q.cs[1:0]),
        .sel_out (sel_clean)
    );

    function automatic logic [IDXW-1:0] tail_last(input tail_e t);
        return (t == T_TO_V86) ? IDXW'(TAIL_MAX - 1) : IDXW'(1);
    endfunction

    // flags image merge for the committed return
    always_comb begin
        unique case (q.head)
            H_REAL:
                fl_new = os16 ? {flags_in[FLW-1:16], q.fl[15:0]}
                              : (q.fl & REAL_POP_KEEP) | (flags_in & REAL_CUR_KEEP);
            H_FROM_V86:
                fl_new = os16 ? {flags_in[FLW-1:16], q.fl[15:14], flags_in[13:12], q.fl[11:0]}
                              : (q.fl & ~V86_CUR_KEEP) | (flags_in & V86_CUR_KEEP);
            default:
                fl_new = q.fl;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.fv   = 1'b0;
        d.tret = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    unique case (head_now)
                        H_TASK: begin
                            d.done = 1'b1;
                            d.tret = 1'b1;
                        end
                        H_FAULT: begin
                            d.done  = 1'b1;
                            d.fv    = 1'b1;
                            d.fcode = VEC_GP;
                        end
                        default: begin
                            d.st   = S_HEAD;
                            d.head = head_now;
                            d.idx  = '0;
                            d.ptr  = sp_in;
                        end
                    endcase
                end
            end
            S_HEAD: begin
                if (pop_ack) begin
                    case (q.idx)
                        IDXW'(0): d.ip = pop_w;
                        IDXW'(1): d.cs = pop_w[SELW-1:0];
                        default:  d.fl = pop_w[FLW-1:0];
                    endcase
                    d.ptr = q.ptr + step_w;
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IDXW'(HEAD_POPS - 1)) begin
                        d.st  = S_DECIDE;
                        d.idx = '0;
                    end
                end
            end
            S_DECIDE: begin
                if (!lma && (q.ip > XLEN'(cs_limit))) begin
                    d.st    = S_IDLE;
                    d.done  = 1'b1;
                    d.fv    = 1'b1;
                    d.fcode = VEC_GP;
                end else begin
                    d.tail = tail_now;
                    d.idx  = '0;
                    d.st   = (tail_now == T_NONE) ? S_COMMIT : S_TAIL;
                end
            end
            S_TAIL: begin
                if (pop_ack) begin
                    if (q.idx == IDXW'(0)) d.tsp = pop_w;
                    if (q.idx == IDXW'(1)) d.tss = pop_w[SELW-1:0];
                    for (int i = 0; i < NSEG; i++) begin
                        if (q.idx == IDXW'(i + 2)) d.tsel[i*SELW +: SELW] = pop_w[SELW-1:0];
                    end
                    d.ptr = q.ptr + step_w;
                    d.idx = q.idx + 1'b1;
                    if (q.idx == tail_last(q.tail)) d.st = S_COMMIT;
                end
            end
            S_COMMIT: begin
                d.st   = S_IDLE;
                d.done = 1'b1;
                d.o_ip = q.ip;
                d.o_cs = q.cs;
                d.o_fl = fl_new;
                unique case (q.tail)
                    T_NONE: begin
                        d.o_sp  = q.ptr;
                        d.o_ss  = ss_in;
                        d.o_sel = sel_in;
                        d.o_cpl = cpl_in;
                    end
                    T_OUTER: begin
                        d.o_sp  = q.tsp;
                        d.o_ss  = q.tss;
                        d.o_sel = sel_clean;
                        d.o_cpl = q.cs[1:0];
                    end
                    T_TO_V86: begin
                        d.o_sp  = q.tsp;
                        d.o_ss  = q.tss;
                        d.o_sel = q.tsel;
                        d.o_cpl = 2'd3;
                    end
                    default: begin
                        d.o_sp  = q.tsp;
                        d.o_ss  = q.tss;
                        d.o_sel = sel_in;
                        d.o_cpl = cpl_in;
                    end
                endcase
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pop_req     = (q.st == S_HEAD) || (q.st == S_TAIL);
    assign pop_addr    = q.ptr;
    assign done        = q.done;
    assign fault_valid = q.fv;
    assign fault_code  = q.fcode;
    assign task_ret    = q.tret;
    assign ip_out      = q.o_ip;
    assign cs_out      = q.o_cs;
    assign flags_out   = q.o_fl;
    assign sp_out      = q.o_sp;
    assign ss_out      = q.o_ss;
    assign sel_out     = q.o_sel;
    assign cpl_out     = q.o_cpl;

    // a stalled read keeps its request and address
    p_hold_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !pop_ack |=> pop_req && $stable(pop_addr));

    // consecutive pops move by one operand step
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && pop_ack |=> !pop_req || (pop_addr == $past(pop_addr) + $past(step_w)));

    // a fault leaves restored state untouched and reports vector 13
    p_fault_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> done && !task_ret && fault_code == VEC_GP && $stable(ip_out)
                        && $stable(sp_out) && $stable(sel_out) && $stable(cpl_out)
                        && $stable(flags_out));

    // a nested task return commits nothing
    p_task_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        task_ret |-> done && $stable(ip_out) && $stable(cs_out) && $stable(cpl_out));

    // completion never overlaps an outstanding read
    p_done_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pop_req);

endmodule

// File: tb/test_iret_seq.sv
module test_iret_seq;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pe = 1'b0, lma = 1'b0;
    logic [31:0] flags_in = '0;
    logic [1:0]  cpl_in = '0, osize = '0;
    logic [63:0] sp_in = '0;
    logic [15:0] ss_in = 16'h0028;
    logic [63:0] sel_in = 64'h0020_0018_0010_0003;
    logic [7:0]  seg_dpl = 8'h34;
    logic [3:0]  seg_dnc = 4'b0111;
    logic [31:0] cs_limit = 32'hFFFF_FFFF;
    logic        pop_req, pop_ack = 1'b0;
    logic [63:0] pop_addr, pop_data = '0;
    logic        done, fault_valid, task_ret;
    logic [7:0]  fault_code;
    logic [63:0] ip_out, sp_out, sel_out;
    logic [15:0] cs_out, ss_out;
    logic [31:0] flags_out;
    logic [1:0]  cpl_out;

    iret_seq i_iret_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pe(pe), .lma(lma),
        .flags_in(flags_in), .cpl_in(cpl_in), .osize(osize), .sp_in(sp_in),
        .ss_in(ss_in), .sel_in(sel_in), .seg_dpl(seg_dpl), .seg_dnc(seg_dnc),
        .cs_limit(cs_limit), .pop_req(pop_req), .pop_addr(pop_addr),
        .pop_ack(pop_ack), .pop_data(pop_data), .done(done),
        .fault_valid(fault_valid), .fault_code(fault_code), .task_ret(task_ret),
        .ip_out(ip_out), .cs_out(cs_out), .flags_out(flags_out), .sp_out(sp_out),
        .ss_out(ss_out), .sel_out(sel_out), .cpl_out(cpl_out)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // model of committed architectural state
    logic [63:0] m_ip = '0, m_sp = '0, m_sel = '0;
    logic [15:0] m_cs = '0, m_ss = '0;
    logic [31:0] m_fl = '0;
    logic [1:0]  m_cpl = '0;
    // expected state of a successful return
    logic [63:0] e_ip, e_sp, e_sel;
    logic [15:0] e_cs, e_ss;
    logic [31:0] e_fl;
    logic [1:0]  e_cpl;
    logic [63:0] stk[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic p, input logic l, input logic [31:0] f,
                         input logic [1:0] c, input logic [1:0] os, input logic [63:0] sp);
        pe = p; lma = l; flags_in = f; cpl_in = c; osize = os; sp_in = sp;
    endtask

    task automatic expect_st(input logic [63:0] ip, input logic [15:0] cs, input logic [31:0] fl,
                             input logic [63:0] sp, input logic [15:0] ss, input logic [63:0] sel,
                             input logic [1:0] c);
        e_ip = ip; e_cs = cs; e_fl = fl; e_sp = sp; e_ss = ss; e_sel = sel; e_cpl = c;
    endtask

    task automatic cmp_outs(input string tag);
        chk(ip_out == m_ip, {tag, " ip_out"}, ip_out, m_ip);
        chk(cs_out == m_cs, {tag, " cs_out"}, 64'(cs_out), 64'(m_cs));
        chk(flags_out == m_fl, {tag, " flags_out"}, 64'(flags_out), 64'(m_fl));
        chk(sp_out == m_sp, {tag, " sp_out"}, sp_out, m_sp);
        chk(ss_out == m_ss, {tag, " ss_out"}, 64'(ss_out), 64'(m_ss));
        chk(sel_out == m_sel, {tag, " sel_out"}, sel_out, m_sel);
        chk(cpl_out == m_cpl, {tag, " cpl_out"}, 64'(cpl_out), 64'(m_cpl));
    endtask

    task automatic run_case(input string tag, input int npops, input bit efault,
                            input bit etask, input bit poke);
        int k = 0, waitc = 0, cyc = 0;
        bit seen = 0;
        logic [63:0] step = 64'd2 << osize;
        @(negedge clk);
        chk(!done, "R14 done idle before start", 64'(done), 64'd0);
        start = 1'b1;
        while (!seen && cyc < 100) begin
            @(negedge clk);
            cyc++;
            start   = poke && (cyc == 4);
            pop_ack = 1'b0;
            if (done) begin
                seen = 1;
                chk(k == npops, {tag, " R2 pop count"}, 64'(k), 64'(npops));
                chk(fault_valid == efault, {tag, " R14 fault_valid"}, 64'(fault_valid), 64'(efault));
                chk(task_ret == etask, {tag, " R6 task_ret"}, 64'(task_ret), 64'(etask));
                if (efault) chk(fault_code == 8'd13, {tag, " R14 fault_code"}, 64'(fault_code), 64'd13);
                if (!efault && !etask) begin
                    m_ip = e_ip; m_cs = e_cs; m_fl = e_fl; m_sp = e_sp;
                    m_ss = e_ss; m_sel = e_sel; m_cpl = e_cpl;
                end
                cmp_outs(tag);
            end else begin
                chk(ip_out == m_ip && sp_out == m_sp && sel_out == m_sel && cpl_out == m_cpl,
                    {tag, " R14 outputs held while busy"}, ip_out, m_ip);
                if (pop_req) begin
                    if (waitc > 0) waitc--;
                    else begin
                        chk(pop_addr == sp_in + 64'(k) * step, {tag, " R2 R13 pop address"},
                            pop_addr, sp_in + 64'(k) * step);
                        chk(k < npops, {tag, " R2 extra pop"}, 64'(k), 64'(npops));
                        pop_data = (k < stk.size()) ? stk[k] : 64'd0;
                        pop_ack  = 1'b1;
                        k++;
                        waitc = poke ? (k % 3) : 0;
                    end
                end
            end
        end
        start = 1'b0;
        pop_ack = 1'b0;
        chk(seen, {tag, " R14 done seen"}, 64'(seen), 64'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!pop_req && !done && !fault_valid && !task_ret, "R1 reset controls",
            {60'd0, pop_req, done, fault_valid, task_ret}, 64'd0);
        cmp_outs("R1 reset outputs");
        rst_n = 1'b1;

        // R2 R3 R4: real-address, 16-bit
        setup(0, 0, 32'h0012_0202, 2'd0, 2'd0, 64'h100);
        stk = '{64'h1_2345, 64'hABCD_F000, 64'hFFFF_8001};
        expect_st(64'h2345, 16'hF000, 32'h0012_8001, 64'h106, 16'h0028, sel_in, 2'd0);
        run_case("R4 real16", 3, 0, 0, 0);

        // R3 R4: real-address, 32-bit
        setup(0, 0, 32'h0013_0000, 2'd0, 2'd1, 64'h200);
        stk = '{64'hDEAD_0000_0000_1000, 64'h5555_0008, 64'h1234_FFFF_FFFF};
        expect_st(64'h1000, 16'h0008, 32'h0037_7FD5, 64'h20C, 16'h0028, sel_in, 2'd0);
        run_case("R3 real32", 3, 0, 0, 0);

        // R5: virtual-8086 with low IOPL
        setup(1, 0, 32'h0002_2000, 2'd3, 2'd1, 64'h300);
        stk = '{};
        run_case("R5 v86 low iopl", 0, 1, 0, 0);

        // R5: virtual-8086 with IOPL 3
        setup(1, 0, 32'h000A_3000, 2'd3, 2'd1, 64'h300);
        stk = '{64'h400, 64'h1234, 64'h0CD5};
        expect_st(64'h400, 16'h1234, 32'h000A_3CD5, 64'h30C, 16'h0028, sel_in, 2'd3);
        run_case("R5 v86 iopl3", 3, 0, 0, 0);

        // R6: nested task, protected then long
        setup(1, 0, 32'h0000_4000, 2'd0, 2'd1, 64'h380);
        stk = '{};
        run_case("R6 task prot", 0, 0, 1, 0);
        setup(1, 1, 32'h0000_4000, 2'd0, 2'd2, 64'h380);
        run_case("R6 task long", 0, 1, 0, 0);

        // R10: protected same level
        setup(1, 0, 32'h0000_0202, 2'd0, 2'd1, 64'h400);
        stk = '{64'h0010_0000, 64'h0008, 64'h0246};
        expect_st(64'h0010_0000, 16'h0008, 32'h0246, 64'h40C, 16'h0028, sel_in, 2'd0);
        run_case("R10 same", 3, 0, 0, 0);

        // R7 R13 R14: to virtual-8086, stalls and a start while busy
        setup(1, 0, 32'h0000_0202, 2'd0, 2'd1, 64'h500);
        stk = '{64'h100, 64'hF000, 64'h0002_0202, 64'hFFF0, 64'hABCD_2000,
                64'h1111, 64'h2222, 64'h3333, 64'hFFFF_4444};
        expect_st(64'h100, 16'hF000, 32'h0002_0202, 64'hFFF0, 16'h2000,
                  64'h4444_3333_2222_1111, 2'd3);
        run_case("R7 to v86", 9, 0, 0, 1);

        // R8 R9: outer level 3
        setup(1, 0, 32'h0000_0202, 2'd0, 2'd1, 64'h600);
        stk = '{64'h2000, 64'h001B, 64'h3202, 64'h7FF0, 64'h0023};
        expect_st(64'h2000, 16'h001B, 32'h3202, 64'h7FF0, 16'h0023,
                  64'h0020_0018_0000_0000, 2'd3);
        run_case("R9 outer3", 5, 0, 0, 0);

        // R8 R9: outer level 1
        setup(1, 0, 32'h0000_0202, 2'd0, 2'd1, 64'h680);
        stk = '{64'h3000, 64'h0009, 64'h0202, 64'h5000, 64'h0011};
        expect_st(64'h3000, 16'h0009, 32'h0202, 64'h5000, 16'h0011,
                  64'h0020_0018_0010_0000, 2'd1);
        run_case("R8 outer1", 5, 0, 0, 0);

        // R11 R3: long same level, 64-bit
        setup(1, 1, 32'h0000_0202, 2'd0, 2'd2, 64'h1000);
        stk = '{64'h0000_7FFF_0000_1234, 64'hFFFF_FFFF_FFFF_0010, 64'h0000_0001_0000_0246,
                64'h0000_7FFF_FFFF_E000, 64'h1234_0000_0000_0018};
        expect_st(64'h0000_7FFF_0000_1234, 16'h0010, 32'h0246, 64'h0000_7FFF_FFFF_E000,
                  16'h0018, sel_in, 2'd0);
        run_case("R11 long same", 5, 0, 0, 0);

        // R8 R9: long outer
        setup(1, 1, 32'h0000_0202, 2'd0, 2'd2, 64'h2000);
        stk = '{64'h0000_7FFF_0000_5678, 64'h002B, 64'h0246, 64'h0000_7FFF_FFFF_C000, 64'h0033};
        expect_st(64'h0000_7FFF_0000_5678, 16'h002B, 32'h0246, 64'h0000_7FFF_FFFF_C000,
                  16'h0033, 64'h0020_0018_0000_0000, 2'd3);
        run_case("R9 long outer", 5, 0, 0, 0);

        // R12: limit fault, then exactly at the limit
        cs_limit = 32'h0000_8FFF;
        setup(1, 0, 32'h0000_0002, 2'd0, 2'd0, 64'h700);
        stk = '{64'h9000, 64'h0008, 64'h0002};
        run_case("R12 over limit", 3, 1, 0, 0);
        stk = '{64'h8FFF, 64'h0008, 64'h0002};
        expect_st(64'h8FFF, 16'h0008, 32'h0002, 64'h706, 16'h0028, sel_in, 2'd0);
        run_case("R12 at limit", 3, 0, 0, 0);

        @(negedge clk);
        chk(!done, "R14 single done pulse", 64'(done), 64'd0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R14 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule